// File: doc/BRIEF.md
# Bridge Posted/Delayed Transaction Queue

This block sits inside a bus-to-bus bridge, between the request port facing the initiator bus and the forwarding port facing the target bus. Both sides use transaction-level handshakes instead of the electrical pin protocol. Each incoming command is first sorted into one of three classes. Memory writes and write-and-invalidate are posted: the initiator is told the write is complete once it sits in an internal FIFO. The FIFO later forwards each write to the target side, unchanged and in arrival order. I/O and configuration writes, and every kind of read, are delayed: the initiator receives a retry, and the request is entered in a small table.

The forwarding port presents one transaction at a time. A delayed request carries its table index as a tag. The target side sends back a completion carrying that tag, and the completion is stored in the entry. When the initiator repeats the identical request, the stored completion is returned and the entry is released. Writes are never combined, byte-merged or collapsed, so every accepted write leaves the block as its own transaction.

Top module: `bridge_txn_queue`

## Requirements
- R1: Command codes 0111 (memory write) and 1111 (write-and-invalidate) are posted. When the posted FIFO is not full, the response one cycle after the request is code 01 (posted-complete), and the write is appended to the posted FIFO.
- R2: Command codes 0011 (I/O write), 1011 (configuration write), 0110, 1110, 1100 (memory reads), 0010 (I/O read) and 1010 (configuration read) are delayed. A first request that matches no entry, made while the table has a free entry, gets response code 10 (retry). The request is stored in the lowest-numbered free entry.
- R3: Any other command code gets no response (rsp_valid stays 0) and creates no entry in either queue.
- R4: The forwarding port presents each accepted posted write exactly once, in acceptance order. Its command, address, byte enables and data are unchanged, and fwd_posted is 1. Two writes are never merged, even when they go to the same or adjacent addresses.
- R5: When no transfer is being held, a non-empty posted FIFO has priority on the forwarding port. Otherwise the port presents the oldest delayed entry not yet forwarded, with fwd_posted 0 and fwd_tag equal to its table index.
- R6: A delayed request matches an entry only when command, address and byte enables are all equal, and, for the write commands, the data as well. A match on an entry that has no completion yet gets retry (10) and does not create a second entry.
- R7: A completion (cpl_valid with cpl_tag) is stored in that entry. The next matching request gets code 11 (done), together with the stored rsp_rdata and rsp_status. The entry is then freed.
- R8: A non-matching delayed request that arrives while all 4 table entries are in use gets retry and creates no entry.
- R9: A posted request that arrives while all 8 FIFO slots are in use gets retry (10) and is not stored.
- R10: A delayed write is reported done only after its completion has arrived from the target side. Until then every repeat of the request gets retry.
- R11: After reset, rsp_valid and fwd_valid are 0.
- R12: If fwd_valid is 1 and fwd_ready is 0, the same transaction stays on the forwarding port in the next cycle, even if a posted write arrives in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Initiator request present this cycle |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | AW | Request address |
| req_be | input | DW/8 | Byte enables |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_code | output | 2 | 01 posted-complete, 10 retry, 11 done |
| rsp_rdata | output | DW | Completion data on done |
| rsp_status | output | 1 | Target status on done |
| fwd_valid | output | 1 | Transaction offered to the target side |
| fwd_ready | input | 1 | Target side accepts the offered transaction |
| fwd_posted | output | 1 | Offered transaction is a posted write |
| fwd_cmd | output | 4 | Offered command |
| fwd_addr | output | AW | Offered address |
| fwd_be | output | DW/8 | Offered byte enables |
| fwd_wdata | output | DW | Offered write data |
| fwd_tag | output | log2(DT_DEPTH) | Table index of an offered delayed request |
| cpl_valid | input | 1 | Completion from the target side |
| cpl_tag | input | log2(DT_DEPTH) | Entry that the completion belongs to |
| cpl_rdata | input | DW | Read data for the completion |
| cpl_status | input | 1 | Target status for the completion |

## Verification
A response always appears exactly one cycle after its request, on the registered rsp outputs. A request sampled at a rising edge affects the queues from that same edge, so the forwarding port can show a newly accepted item right after that edge. A completion sampled at an edge can be returned to a matching request no earlier than the following cycle. The bench drives inputs just after a falling edge and advances its behavioural model across the rising edge. It compares responses and the forwarding port at the next falling edge, so every result is checked in the cycle it becomes due.

// File: rtl/bridge_txn_pkg.sv
package bridge_txn_pkg;

  localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
  localparam logic [3:0] CMD_MEM_WRINV  = 4'b1111;
  localparam logic [3:0] CMD_IO_WR      = 4'b0011;
  localparam logic [3:0] CMD_CFG_WR     = 4'b1011;
  localparam logic [3:0] CMD_MEM_RD     = 4'b0110;
  localparam logic [3:0] CMD_MEM_RDLINE = 4'b1110;
  localparam logic [3:0] CMD_MEM_RDMULT = 4'b1100;
  localparam logic [3:0] CMD_IO_RD      = 4'b0010;
  localparam logic [3:0] CMD_CFG_RD     = 4'b1010;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_POSTED = 2'd1,
    K_DLY_WR = 2'd2,
    K_DLY_RD = 2'd3
  } txn_kind_t;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'b00,
    RSP_POSTED = 2'b01,
    RSP_RETRY  = 2'b10,
    RSP_DONE   = 2'b11
  } rsp_kind_t;

  // Sorts a command code into its handling class.
  function automatic txn_kind_t classify_cmd(input logic [3:0] c);
    case (c)
      CMD_MEM_WR, CMD_MEM_WRINV:                  return K_POSTED;
      CMD_IO_WR, CMD_CFG_WR:                      return K_DLY_WR;
      CMD_MEM_RD, CMD_MEM_RDLINE, CMD_MEM_RDMULT,
      CMD_IO_RD, CMD_CFG_RD:                      return K_DLY_RD;
      default:                                    return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bq_fifo.sv
module bq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= ptr_next(wp);
      if (rd_en) rp <= ptr_next(rp);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: the producer never pushes into a full store
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!full || rd_en));
  // R4: an entry is only taken when one is held
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/bq_dly_table.sv
module bq_dly_table #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_go,
  input  logic                     req_is_wr,
  input  logic [3:0]               req_cmd,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW/8-1:0]          req_be,
  input  logic [DW-1:0]            req_wdata,
  output logic                     hit,
  output logic                     hit_done,
  output logic [DW-1:0]            hit_rdata,
  output logic                     hit_status,
  output logic                     tbl_full,
  output logic                     alloc_en,
  output logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic                     issue_en,
  input  logic [$clog2(DEPTH)-1:0] issue_idx,
  output logic [3:0]               rd_cmd,
  output logic [AW-1:0]            rd_addr,
  output logic [DW/8-1:0]          rd_be,
  output logic [DW-1:0]            rd_wdata,
  input  logic                     cpl_valid,
  input  logic [$clog2(DEPTH)-1:0] cpl_tag,
  input  logic [DW-1:0]            cpl_rdata,
  input  logic                     cpl_status
);
  localparam int IW  = $clog2(DEPTH);
  localparam int BEW = DW / 8;

  logic [DEPTH-1:0] e_valid, e_issued, e_done, e_wr, match_vec;
  logic [3:0]       e_cmd    [DEPTH];
  logic [AW-1:0]    e_addr   [DEPTH];
  logic [BEW-1:0]   e_be     [DEPTH];
  logic [DW-1:0]    e_wdata  [DEPTH];
  logic [DW-1:0]    e_rdata  [DEPTH];
  logic [DEPTH-1:0] e_status;
  logic [IW-1:0]    hit_idx;
  logic             free_en;

  // Identity test used by the retry matcher.
  function automatic logic same_txn(input logic [3:0] ca, input logic [3:0] cb,
                                    input logic [AW-1:0] aa, input logic [AW-1:0] ab,
                                    input logic [BEW-1:0] ba, input logic [BEW-1:0] bb,
                                    input logic wr, input logic [DW-1:0] da,
                                    input logic [DW-1:0] db);
    return (ca == cb) && (aa == ab) && (ba == bb) && (!wr || (da == db));
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign match_vec[g] = e_valid[g] &&
      same_txn(e_cmd[g], req_cmd, e_addr[g], req_addr, e_be[g], req_be,
               e_wr[g], e_wdata[g], req_wdata);
  end

  always_comb begin
    hit_idx   = '0;
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IW'(i);
      if (!e_valid[i])  alloc_idx = IW'(i);
    end
  end

  assign hit        = |match_vec;
  assign hit_done   = e_done[hit_idx];
  assign hit_rdata  = e_rdata[hit_idx];
  assign hit_status = e_status[hit_idx];
  assign tbl_full   = &e_valid;
  assign alloc_en   = req_go && !hit && !tbl_full;
  assign free_en    = req_go && hit && hit_done;

  assign rd_cmd   = e_cmd[issue_idx];
  assign rd_addr  = e_addr[issue_idx];
  assign rd_be    = e_be[issue_idx];
  assign rd_wdata = e_wdata[issue_idx];

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      e_cmd[alloc_idx]   <= req_cmd;
      e_addr[alloc_idx]  <= req_addr;
      e_be[alloc_idx]    <= req_be;
      e_wdata[alloc_idx] <= req_wdata;
    end
    if (cpl_valid) begin
      e_rdata[cpl_tag]  <= cpl_rdata;
      e_status[cpl_tag] <= cpl_status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid  <= '0;
      e_issued <= '0;
      e_done   <= '0;
      e_wr     <= '0;
    end else begin
      if (alloc_en) begin
        e_valid[alloc_idx]  <= 1'b1;
        e_issued[alloc_idx] <= 1'b0;
        e_done[alloc_idx]   <= 1'b0;
        e_wr[alloc_idx]     <= req_is_wr;
      end
      if (free_en)   e_valid[hit_idx]   <= 1'b0;
      if (issue_en)  e_issued[issue_idx] <= 1'b1;
      if (cpl_valid) e_done[cpl_tag]    <= 1'b1;
    end
  end

  // R6: a repeated request never leaves two equal entries behind
  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  // R5: only a held, not yet forwarded entry is issued
  assert_issue_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> (e_valid[issue_idx] && !e_issued[issue_idx]));
  // R7: a completion lands on a forwarded entry still waiting for one
  assert_cpl_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (e_valid[cpl_tag] && e_issued[cpl_tag] && !e_done[cpl_tag]));
  // R10: an entry is released only once its completion is stored
  assert_free_after_cpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> e_done[hit_idx]);

endmodule

// File: rtl/bridge_txn_queue.sv
module bridge_txn_queue
  import bridge_txn_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int PF_DEPTH = 8,
  parameter int DT_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [3:0]                  req_cmd,
  input  logic [AW-1:0]               req_addr,
  input  logic [DW/8-1:0]             req_be,
  input  logic [DW-1:0]               req_wdata,
  output logic                        rsp_valid,
  output logic [1:0]                  rsp_code,
  output logic [DW-1:0]               rsp_rdata,
  output logic                        rsp_status,
  output logic                        fwd_valid,
  input  logic                        fwd_ready,
  output logic                        fwd_posted,
  output logic [3:0]                  fwd_cmd,
  output logic [AW-1:0]               fwd_addr,
  output logic [DW/8-1:0]             fwd_be,
  output logic [DW-1:0]               fwd_wdata,
  output logic [$clog2(DT_DEPTH)-1:0] fwd_tag,
  input  logic                        cpl_valid,
  input  logic [$clog2(DT_DEPTH)-1:0] cpl_tag,
  input  logic [DW-1:0]               cpl_rdata,
  input  logic                        cpl_status
);
  localparam int IW  = $clog2(DT_DEPTH);
  localparam int BEW = DW / 8;
  localparam int PFW = 4 + AW + BEW + DW;

  txn_kind_t  kind;
  rsp_kind_t  next_code;
  logic       posted_go, dly_go, pf_wr, pf_rd, pf_empty, pf_full;
  logic [PFW-1:0] pf_head;
  logic       hit, hit_done, hit_status, tbl_full, alloc_en;
  logic [DW-1:0] hit_rdata;
  logic [IW-1:0] alloc_idx, iq_head;
  logic       iq_rd, iq_empty, iq_full;
  logic [3:0] d_cmd;
  logic [AW-1:0] d_addr;
  logic [BEW-1:0] d_be;
  logic [DW-1:0]  d_wdata;
  logic       sel_posted, hold_q, held_posted_q, fire, done_now;

  assign kind      = classify_cmd(req_cmd);
  assign posted_go = req_valid && (kind == K_POSTED);
  assign dly_go    = req_valid && ((kind == K_DLY_WR) || (kind == K_DLY_RD));
  assign pf_wr     = posted_go && !pf_full;
  assign done_now  = dly_go && hit && hit_done;

  always_comb begin
    case (kind)
      K_POSTED: next_code = pf_full ? RSP_RETRY : RSP_POSTED;
      K_DLY_WR,
      K_DLY_RD: next_code = done_now ? RSP_DONE : RSP_RETRY;
      default:  next_code = RSP_NONE;
    endcase
  end

  bq_fifo #(.WIDTH(PFW), .DEPTH(PF_DEPTH)) u_posted (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pf_wr), .wr_data({req_cmd, req_addr, req_be, req_wdata}),
    .rd_en(pf_rd), .rd_data(pf_head), .empty(pf_empty), .full(pf_full)
  );

  bq_dly_table #(.AW(AW), .DW(DW), .DEPTH(DT_DEPTH)) u_table (
    .clk(clk), .rst_n(rst_n),
    .req_go(dly_go), .req_is_wr(kind == K_DLY_WR),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .hit(hit), .hit_done(hit_done), .hit_rdata(hit_rdata), .hit_status(hit_status),
    .tbl_full(tbl_full), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .issue_en(iq_rd), .issue_idx(iq_head),
    .rd_cmd(d_cmd), .rd_addr(d_addr), .rd_be(d_be), .rd_wdata(d_wdata),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_rdata(cpl_rdata),
    .cpl_status(cpl_status)
  );

  // Allocation order of delayed entries, oldest at the head.
  bq_fifo #(.WIDTH(IW), .DEPTH(DT_DEPTH)) u_order (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_en), .wr_data(alloc_idx),
    .rd_en(iq_rd), .rd_data(iq_head), .empty(iq_empty), .full(iq_full)
  );

  assign sel_posted = hold_q ? held_posted_q : !pf_empty;
  assign fwd_valid  = sel_posted ? !pf_empty : !iq_empty;
  assign fire       = fwd_valid && fwd_ready;
  assign pf_rd      = fire && sel_posted;
  assign iq_rd      = fire && !sel_posted;
  assign fwd_posted = sel_posted;
  assign fwd_tag    = sel_posted ? '0 : iq_head;

  always_comb begin
    if (sel_posted) begin
      {fwd_cmd, fwd_addr, fwd_be, fwd_wdata} = pf_head;
    end else begin
      fwd_cmd   = d_cmd;
      fwd_addr  = d_addr;
      fwd_be    = d_be;
      fwd_wdata = d_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q        <= 1'b0;
      held_posted_q <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_code      <= RSP_NONE;
      rsp_rdata     <= '0;
      rsp_status    <= 1'b0;
    end else begin
      hold_q        <= fwd_valid && !fwd_ready;
      held_posted_q <= sel_posted;
      rsp_valid     <= req_valid && (kind != K_NONE);
      rsp_code      <= next_code;
      rsp_rdata     <= done_now ? hit_rdata : '0;
      rsp_status    <= done_now && hit_status;
    end
  end

  // R12: a stalled offer stays put until taken
  assert_fwd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_posted) &&
      $stable(fwd_cmd) && $stable(fwd_addr) && $stable(fwd_tag) && $stable(fwd_be)));
  // R3: every response answers a request of the previous cycle
  assert_rsp_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  // R2: the order queue never outgrows the table
  assert_order_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !iq_full);
  // R7: a done response always follows a delayed request
  assert_done_is_delayed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RSP_DONE) |-> $past(dly_go));

endmodule

// File: tb/sim_bridge_txn_queue.sv
`timescale 1ns/1ps
module sim_bridge_txn_queue;
  localparam int AW = 32, DW = 32, BEW = 4, NT = 4, NP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, fwd_ready = 1'b0, cpl_valid = 1'b0, cpl_status = 1'b0;
  logic [3:0] req_cmd = '0;
  logic [AW-1:0] req_addr = '0;
  logic [BEW-1:0] req_be = '0;
  logic [DW-1:0] req_wdata = '0, cpl_rdata = '0;
  logic [1:0] cpl_tag = '0;
  logic rsp_valid, rsp_status, fwd_valid, fwd_posted;
  logic [1:0] rsp_code, fwd_tag;
  logic [DW-1:0] rsp_rdata, fwd_wdata;
  logic [3:0] fwd_cmd;
  logic [AW-1:0] fwd_addr;
  logic [BEW-1:0] fwd_be;

  bridge_txn_queue u0 (.*);

  typedef struct packed {
    logic [3:0] cmd; logic [AW-1:0] addr; logic [BEW-1:0] be; logic [DW-1:0] wd;
  } txn_t;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  txn_t pq[$];
  int   iq[$];
  int   await_q[$];
  bit   mv[NT], mdone[NT], mst[NT];
  txn_t mt[NT];
  logic [DW-1:0] mrd[NT];
  bit   mhold = 0, mheld_p = 0;
  bit   exp_rv = 0; logic [1:0] exp_code = 0; logic [DW-1:0] exp_rd = 0; bit exp_st = 0;
  string exp_tag = "R11";
  bit   auto_cpl = 0;
  int   cpl_seq = 0;

  // stimulus for the next cycle
  bit s_rv = 0; logic [3:0] s_cmd = 0; logic [AW-1:0] s_addr = 0;
  logic [BEW-1:0] s_be = 0; logic [DW-1:0] s_wd = 0;
  bit s_rdy = 0;

  function automatic int kind_of(input logic [3:0] c);
    if (c == 4'b0111 || c == 4'b1111) return 1;
    if (c == 4'b0011 || c == 4'b1011) return 2;
    if (c == 4'b0110 || c == 4'b1110 || c == 4'b1100 || c == 4'b0010 || c == 4'b1010)
      return 3;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit sel_p, fv, fire, pfull;
    int k, hi, fr;
    txn_t r;
    sel_p = mhold ? mheld_p : (pq.size() > 0);
    fv    = sel_p ? (pq.size() > 0) : (iq.size() > 0);
    fire  = fv && s_rdy;
    pfull = (pq.size() == NP);
    exp_rv = 0; exp_code = 0; exp_rd = 0; exp_st = 0;
    r = '{cmd: s_cmd, addr: s_addr, be: s_be, wd: s_wd};
    if (s_rv) begin
      k = kind_of(s_cmd);
      if (k == 0) begin
        exp_tag = "R3";
      end else if (k == 1) begin
        exp_rv = 1;
        if (pfull) begin exp_code = 2'b10; exp_tag = "R9"; end
        else begin exp_code = 2'b01; exp_tag = "R1"; pq.push_back(r); end
      end else begin
        exp_rv = 1; hi = -1; fr = -1;
        for (int i = 0; i < NT; i++) begin
          if (mv[i] && mt[i].cmd == r.cmd && mt[i].addr == r.addr && mt[i].be == r.be &&
              (k == 3 || mt[i].wd == r.wd)) hi = i;
        end
        for (int i = NT - 1; i >= 0; i--) if (!mv[i]) fr = i;
        if (hi >= 0 && mdone[hi]) begin
          exp_code = 2'b11; exp_rd = mrd[hi]; exp_st = mst[hi]; mv[hi] = 0; exp_tag = "R7";
        end else if (hi >= 0) begin
          exp_code = 2'b10; exp_tag = "R6 R10";
        end else if (fr < 0) begin
          exp_code = 2'b10; exp_tag = "R8";
        end else begin
          exp_code = 2'b10; exp_tag = "R2";
          mv[fr] = 1; mdone[fr] = 0; mt[fr] = r; iq.push_back(fr);
        end
      end
    end
    if (fire) begin
      if (sel_p) void'(pq.pop_front());
      else await_q.push_back(iq.pop_front());
    end
    mhold = fv && !s_rdy;
    mheld_p = sel_p;
  endtask

  task automatic check_outputs();
    bit sel_p, fv;
    txn_t h;
    check(rsp_valid == exp_rv, exp_tag, "rsp_valid", rsp_valid, exp_rv);
    if (exp_rv) begin
      check(rsp_code == exp_code, exp_tag, "rsp_code", rsp_code, exp_code);
      if (exp_code == 2'b11) begin
        check(rsp_rdata == exp_rd, "R7", "rsp_rdata", rsp_rdata, exp_rd);
        check(rsp_status == exp_st, "R7", "rsp_status", rsp_status, exp_st);
      end
    end
    sel_p = mhold ? mheld_p : (pq.size() > 0);
    fv    = sel_p ? (pq.size() > 0) : (iq.size() > 0);
    check(fwd_valid == fv, "R4 R5 R12", "fwd_valid", fwd_valid, fv);
    if (fv && fwd_valid) begin
      h = sel_p ? pq[0] : mt[iq[0]];
      check(fwd_posted == sel_p, "R5 R12", "fwd_posted", fwd_posted, sel_p);
      check({fwd_cmd, fwd_addr, fwd_be, fwd_wdata} == h, sel_p ? "R4" : "R5",
            "fwd_txn", {fwd_cmd, fwd_addr[27:0]}, {h.cmd, h.addr[27:0]});
      if (!sel_p) check(fwd_tag == 2'(iq[0]), "R5", "fwd_tag", fwd_tag, iq[0]);
    end
  endtask

  task automatic tick();
    bit cv = 0;
    int t = 0;
    logic [DW-1:0] crd;
    bit cst;
    crd = '0; cst = 0;
    if (auto_cpl && await_q.size() > 0 && $urandom_range(0, 2) == 0) begin
      cv = 1; t = await_q.pop_front();
      cpl_seq++;
      crd = DW'(32'hC0DE_0000 + cpl_seq * 7 + t); cst = $urandom_range(0, 1);
    end
    req_valid = s_rv; req_cmd = s_cmd; req_addr = s_addr; req_be = s_be; req_wdata = s_wd;
    fwd_ready = s_rdy; cpl_valid = cv; cpl_tag = 2'(t); cpl_rdata = crd; cpl_status = cst;
    model_step();
    if (cv) begin mdone[t] = 1; mrd[t] = crd; mst[t] = cst; end
    @(posedge clk); @(negedge clk);
    check_outputs();
    s_rv = 0;
  endtask

  task automatic req(input logic [3:0] c, input logic [AW-1:0] a,
                     input logic [BEW-1:0] b, input logic [DW-1:0] d);
    s_rv = 1; s_cmd = c; s_addr = a; s_be = b; s_wd = d;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] cmds[11] = '{4'b0111, 4'b1111, 4'b0011, 4'b1011, 4'b0110, 4'b1110,
                             4'b1100, 4'b0010, 4'b1010, 4'b0000, 4'b0101};
    for (int i = 0; i < NT; i++) begin mv[i] = 0; mdone[i] = 0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(rsp_valid == 0, "R11", "rsp_valid", rsp_valid, 0);
    check(fwd_valid == 0, "R11", "fwd_valid", fwd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R9: stalled target, same and adjacent addresses, overfill
    s_rdy = 0;
    req(4'b0111, 32'h1000, 4'hF, 32'h11);
    req(4'b0111, 32'h1000, 4'h1, 32'h22);
    req(4'b0111, 32'h1000, 4'h2, 32'h33);
    req(4'b1111, 32'h1004, 4'hF, 32'h44);
    for (int i = 0; i < 6; i++) req(4'b0111, 32'h2000 + 4 * i, 4'hF, 32'h100 + i);
    // R3: unknown codes leave both queues untouched
    req(4'b0000, 32'h3000, 4'hF, 32'h0);
    req(4'b1101, 32'h3000, 4'hF, 32'h0);
    s_rdy = 1; idle(12);

    // R2 R6 R8 R12: fill the table while stalled, then a posted write behind it
    s_rdy = 0;
    req(4'b0011, 32'h40, 4'hF, 32'hAA);
    req(4'b0011, 32'h40, 4'hF, 32'hAA);
    req(4'b0011, 32'h40, 4'hF, 32'hAB);
    req(4'b1010, 32'h80, 4'hF, 32'h0);
    req(4'b0110, 32'h90, 4'h3, 32'h0);
    req(4'b0010, 32'hA0, 4'hF, 32'h0);
    req(4'b0111, 32'h10, 4'hF, 32'h55);
    idle(2);
    s_rdy = 1; auto_cpl = 1;
    // R10: repeat before completions arrive
    req(4'b0011, 32'h40, 4'hF, 32'hAA);
    idle(30);
    // R7: collect completions
    req(4'b0011, 32'h40, 4'hF, 32'hAA);
    req(4'b0011, 32'h40, 4'hF, 32'hAB);
    req(4'b1010, 32'h80, 4'hF, 32'h0);
    req(4'b0110, 32'h90, 4'h3, 32'h0);
    req(4'b0010, 32'hA0, 4'hF, 32'h0);
    idle(10);

    // mixed traffic over a small pool so repeats and matches are frequent
    for (int n = 0; n < 4000; n++) begin
      s_rdy = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 1) == 1) begin
        s_rv = 1;
        s_cmd = cmds[$urandom_range(0, 10)];
        s_addr = 32'h500 + 4 * $urandom_range(0, 2);
        s_be = $urandom_range(0, 1) ? 4'hF : 4'h3;
        s_wd = 32'($urandom_range(0, 1));
      end
      tick();
    end
    s_rdy = 1; idle(40);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule